// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address for 4 KiB pages. It reads two 32-bit entries from memory, one at each level. A translation request carries the linear address and an access type. The walker takes the directory base from its base input when the request is accepted. It reads a directory entry to find a page table, then reads a table entry to find the page frame. The frame is joined with the byte offset of the linear address.

A memory read port carries the walk, and only one read is outstanding at a time. The result has the physical address, the read/write and user/supervisor flags from each level, and their merged values. A separate checker uses those flags to decide access rights. When either entry is not present, the walk stops and reports a fault. The fault names the level that was missing and gives the linear address that faulted. The result is held until the consumer acknowledges it.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, `res_valid` is 0, `mem_req_valid` is 0 and `res_fault_addr` is 0.
- R2: The first read goes to `{dir_base[31:12], lin[31:22], 2'b00}`. That is the directory base plus four times the directory index, and the low 12 bits of the base are ignored. For linear address 0x12345678 the directory index is 0x048.
- R3: When directory entry bit 0 (present) is 1, the second read goes to `{pde[31:12], lin[21:12], 2'b00}`. For 0x12345678 the table index is 0x345.
- R4: When both entries are present, the result has `res_fault`=0 and `res_phys = {pte[31:12], lin[11:0]}`. For 0x12345678 the offset is 0x678.
- R5: When directory entry bit 0 is 0, the walk ends with no second read. The result has `res_fault`=1, `res_fault_level`=0 and `res_phys`=0.
- R6: When the table entry bit 0 is 0, the result has `res_fault`=1, `res_fault_level`=1 and `res_phys`=0.
- R7: Entry bit 1 is read/write and bit 2 is user/supervisor. `res_dir_flags` equals `{pde[2], pde[1]}`. On a fault-free result, `res_tbl_flags` equals `{pte[2], pte[1]}`, `res_rw` is `pde[1] & pte[1]` and `res_us` is `pde[2] & pte[2]`. On a faulting result these three are 0. `res_write` returns the access type of the request.
- R8: A request is taken only while `req_ready` is 1. Changes to `req_valid`, `req_lin` and `dir_base` during a walk do not affect that walk's result.
- R9: `res_valid` and all result fields stay stable until `res_ready` is 1. On the cycle after that, `req_ready` is 1 again.
- R10: `res_fault_addr` shows the faulting linear address from the fault result until the next request is accepted, and then it reads 0.
- R11: `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready` is taken. The walker then waits any number of cycles for `mem_rsp_valid` and raises no other read in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request taken |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Access type, 1 for write |
| dir_base | input | 32 | Physical base of the directory |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory read accepted |
| mem_req_addr | output | 32 | Physical address of the entry read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result acknowledged |
| res_phys | output | 32 | Physical address |
| res_fault | output | 1 | Not-present fault |
| res_fault_level | output | 1 | 0 for directory, 1 for table |
| res_fault_addr | output | 32 | Faulting linear address |
| res_dir_flags | output | 2 | Directory {user, write} flags |
| res_tbl_flags | output | 2 | Table {user, write} flags |
| res_rw | output | 1 | Merged write permission |
| res_us | output | 1 | Merged user permission |
| res_write | output | 1 | Access type of the request |

## Verification
The hardest case to reach is a request or memory event that overlaps a walk already in progress. One example is a new linear address that appears on the request port while the walker is still waiting on its second read. Another is a read that is held unaccepted for several cycles before the response comes back late. The stimulus keeps `req_valid` high with changed address and base values through the whole walk. It also stalls `mem_req_ready` and the response by random amounts. The result must still match the first request. Random entries clear the present bit at each level often enough to reach both fault paths many times.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W   = 32,
  parameter int DIR_BITS = 10,
  parameter int TBL_BITS = 10,
  parameter int OFF_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_lin,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] dir_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_phys,
  output logic              res_fault,
  output logic              res_fault_level,
  output logic [ADDR_W-1:0] res_fault_addr,
  output logic [1:0]        res_dir_flags,
  output logic [1:0]        res_tbl_flags,
  output logic              res_rw,
  output logic              res_us,
  output logic              res_write
);
  localparam int FRAME_W = ADDR_W - OFF_BITS;
  localparam int DIR_PAD = OFF_BITS - DIR_BITS;
  localparam int TBL_PAD = OFF_BITS - TBL_BITS;
  localparam int TBL_LO  = OFF_BITS;
  localparam int DIR_LO  = OFF_BITS + TBL_BITS;

  typedef enum logic [2:0] {S_IDLE, S_PDE, S_PTE, S_DONE, S_FAULT} state_t;

  state_t            st;
  logic [ADDR_W-1:0] lin_q, base_q, pde_q, pte_q, fault_addr_q;
  logic              write_q, sent_q, lvl_q;

  wire in_fetch = (st == S_PDE) || (st == S_PTE);
  wire rsp_take = in_fetch && sent_q && mem_rsp_valid;
  wire ok       = (st == S_DONE);

  wire [ADDR_W-1:0] dir_addr = {base_q[ADDR_W-1:OFF_BITS], lin_q[DIR_LO +: DIR_BITS], {DIR_PAD{1'b0}}};
  wire [ADDR_W-1:0] tbl_addr = {pde_q[ADDR_W-1:OFF_BITS], lin_q[TBL_LO +: TBL_BITS], {TBL_PAD{1'b0}}};

  assign req_ready       = (st == S_IDLE);
  assign mem_req_valid   = in_fetch && !sent_q;
  assign mem_req_addr    = (st == S_PTE) ? tbl_addr : dir_addr;
  assign res_valid       = ok || (st == S_FAULT);
  assign res_fault       = (st == S_FAULT);
  assign res_fault_level = lvl_q;
  assign res_fault_addr  = fault_addr_q;
  assign res_phys        = ok ? {pte_q[ADDR_W-1:OFF_BITS], lin_q[OFF_BITS-1:0]} : '0;
  assign res_dir_flags   = pde_q[2:1];
  assign res_tbl_flags   = ok ? pte_q[2:1] : 2'b00;
  assign res_rw          = ok && pde_q[1] && pte_q[1];
  assign res_us          = ok && pde_q[2] && pte_q[2];
  assign res_write       = write_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      lin_q        <= '0;
      base_q       <= '0;
      pde_q        <= '0;
      pte_q        <= '0;
      fault_addr_q <= '0;
      write_q      <= 1'b0;
      sent_q       <= 1'b0;
      lvl_q        <= 1'b0;
    end else begin
      if (mem_req_valid && mem_req_ready) sent_q <= 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          lin_q        <= req_lin;
          base_q       <= dir_base;
          write_q      <= req_write;
          fault_addr_q <= '0;
          pde_q        <= '0;
          pte_q        <= '0;
          sent_q       <= 1'b0;
          st           <= S_PDE;
        end
        S_PDE: if (rsp_take) begin
          sent_q <= 1'b0;
          pde_q  <= mem_rsp_data;
          if (!mem_rsp_data[0]) begin
            lvl_q        <= 1'b0;
            fault_addr_q <= lin_q;
            st           <= S_FAULT;
          end else begin
            st <= S_PTE;
          end
        end
        S_PTE: if (rsp_take) begin
          sent_q <= 1'b0;
          pte_q  <= mem_rsp_data;
          if (!mem_rsp_data[0]) begin
            lvl_q        <= 1'b1;
            fault_addr_q <= lin_q;
            st           <= S_FAULT;
          end else begin
            st <= S_DONE;
          end
        end
        S_DONE, S_FAULT: if (res_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              res_valid,
  input logic              res_ready,
  input logic [ADDR_W-1:0] res_phys,
  input logic              res_fault,
  input logic              res_fault_level,
  input logic [ADDR_W-1:0] res_fault_addr
);
  a_r11_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_phys) && $stable(res_fault)
                                && $stable(res_fault_level) && $stable(res_fault_addr));

  a_r9_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> req_ready && !res_valid);

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready && !res_valid);

  a_r10_fault_addr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> res_fault_addr == '0);

  a_r4_no_phys_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_phys == '0);
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .res_valid(res_valid), .res_ready(res_ready), .res_phys(res_phys), .res_fault(res_fault),
  .res_fault_level(res_fault_level), .res_fault_addr(res_fault_addr)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_lin = '0, dir_base = '0;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_ready = 1'b0;
  logic        req_ready, mem_req_valid, res_valid, res_fault, res_fault_level;
  logic        res_rw, res_us, res_write;
  logic [31:0] mem_req_addr, res_phys, res_fault_addr;
  logic [1:0]  res_dir_flags, res_tbl_flags;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pt_walker dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_dir(input logic [31:0] base, input logic [31:0] lin);
    return {base[31:12], lin[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] f_tbl(input logic [31:0] pde, input logic [31:0] lin);
    return {pde[31:12], lin[21:12], 2'b00};
  endfunction
  function automatic logic [31:0] f_phys(input logic [31:0] pte, input logic [31:0] lin);
    return {pte[31:12], lin[11:0]};
  endfunction

  task automatic serve(input logic [31:0] exp_addr, input logic [31:0] data, input string req);
    logic [31:0] a;
    while (!mem_req_valid) @(negedge clk);
    a = mem_req_addr;
    chk(a == exp_addr, req, a, exp_addr);
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr == a, "R11 read held", mem_req_addr, a);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    repeat ($urandom % 4) begin
      chk(!mem_req_valid, "R11 single outstanding", {31'd0, mem_req_valid}, 32'd0);
      @(negedge clk);
    end
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = $urandom;
  endtask

  task automatic walk(input logic [31:0] lin, input logic [31:0] base, input logic [31:0] pde,
                      input logic [31:0] pte, input bit wr, input bit poke);
    bit flt, lvl;
    logic [31:0] ph;
    logic [1:0] tf;
    flt = !pde[0] || !pte[0];
    lvl = pde[0];
    ph  = flt ? 32'd0 : f_phys(pte, lin);
    tf  = flt ? 2'b00 : pte[2:1];
    req_valid = 1'b1; req_lin = lin; dir_base = base; req_write = wr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    chk(res_fault_addr == 32'd0, "R10 cleared on accept", res_fault_addr, 32'd0);
    if (poke) begin
      req_lin = ~lin; dir_base = ~base; req_write = ~wr;
    end else req_valid = 1'b0;
    serve(f_dir(base, lin), pde, "R2 directory address");
    if (pde[0]) serve(f_tbl(pde, lin), pte, "R3 table address");
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    chk(res_fault == flt, pde[0] ? "R6 table fault flag" : "R5 directory fault flag", {31'd0, res_fault}, {31'd0, flt});
    if (flt) chk(res_fault_level == lvl, lvl ? "R6 level" : "R5 level", {31'd0, res_fault_level}, {31'd0, lvl});
    chk(res_phys == ph, poke ? "R8 busy request ignored" : "R4 physical address", res_phys, ph);
    chk(res_dir_flags == pde[2:1], "R7 directory flags", {30'd0, res_dir_flags}, {30'd0, pde[2:1]});
    chk(res_tbl_flags == tf, "R7 table flags", {30'd0, res_tbl_flags}, {30'd0, tf});
    chk(res_rw == (!flt && pde[1] && pte[1]) && res_us == (!flt && pde[2] && pte[2]) && res_write == wr,
        "R7 merged flags", {29'd0, res_write, res_us, res_rw},
        {29'd0, wr, !flt && pde[2] && pte[2], !flt && pde[1] && pte[1]});
    chk(res_fault_addr == (flt ? lin : 32'd0), "R10 fault address", res_fault_addr, flt ? lin : 32'd0);
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk(res_valid && res_phys == ph && res_fault == flt, "R9 result held", res_phys, ph);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(req_ready && !res_valid, "R9 idle after ack", {31'd0, req_ready}, 32'd1);
    chk(res_fault_addr == (flt ? lin : 32'd0), "R10 fault address kept", res_fault_addr, flt ? lin : 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lin, base, pde, pte;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(req_ready && !res_valid && !mem_req_valid && res_fault_addr == 0, "R1 reset state",
        {req_ready, res_valid, mem_req_valid, 29'd0}, 32'h8000_0000);
    rst_n = 1'b1;
    @(negedge clk);
    walk(32'h1234_5678, 32'h0010_0ABC, 32'h0020_0007, 32'hABCD_E003, 1'b0, 1'b0);
    walk(32'h1234_5678, 32'h0010_0000, 32'h0020_0006, 32'hABCD_E007, 1'b1, 1'b0);
    walk(32'hFFFF_FFFF, 32'hFFFF_F000, 32'h0030_0003, 32'h0040_0006, 1'b1, 1'b0);
    walk(32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_F001, 1'b0, 1'b1);
    walk(32'hDEAD_BEEF, 32'h0050_0000, 32'h0060_0007, 32'h0070_0005, 1'b0, 1'b1);
    for (int i = 0; i < 300; i++) begin
      lin  = $urandom; base = $urandom; pde = $urandom; pte = $urandom;
      pde[0] = ($urandom % 6) != 0;
      pte[0] = ($urandom % 6) != 0;
      walk(lin, base, pde, pte, 1'($urandom), ($urandom % 4) == 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule